// File: doc/BRIEF.md
# Byte-Exchange Serial Link Controller

This block sits on an 8-bit CPU bus and turns a single register write into an 8-bit serial exchange. The written byte is shifted out one bit per CPU clock. A flash memory card returns a byte during the same eight clocks, and that byte replaces the written value in the exchange register. A second, write-only configuration target listens on the same data line. Its clock is the card clock gated by a select bit in the page register, so one write can feed the card, the configuration target, or both.

A page register holds a four-bit flash bank number, two enables for non-volatile storage areas, the configuration-target select and a hand-over flag, all active high. A link register holds the card's active-low select. All registers sit in one 256-byte window on a fixed address page. An active-low override input makes the registers answer on every page.

The serial clock is the CPU clock gated by an enable that changes only while the CPU clock is low, so each pulse is a full clean high phase. Outgoing data changes while the clock is low. Returned data is sampled on the rising clock edge.

Top module: `bxl_top`

## Requirements
- R1: Registers answer only when address bits 15:8 equal the window page (default 0x06). Accesses elsewhere have no effect and read 0x00. While `win_any_n` is low, every page answers. Register offsets within the window are 0x20 (exchange), 0xE0 (page) and 0x12 (link).
- R2: The page register is read and written at offset 0xE0. Its fields are: bits 3:0 on `bank_o`, bit 4 on `hs_nv_en_o`, bit 5 on `set_nv_en_o`, bit 6 on `cfg_sel_o` and bit 7 on `handoff_o`.
- R3: The link register is at offset 0x12. Bit 4 drives `card_cs_n_o` directly, where 1 means the card is deselected. The other bits read as 0.
- R4: A write to offset 0x20 while idle loads the byte and starts an exchange. `busy_o` is then high for exactly 8 clock cycles.
- R5: `sclk_o` gives exactly 8 pulses per exchange and is low while idle. Each pulse rises on a rising edge of `clk`.
- R6: Bits leave on `mosi_o` MSB first. `mosi_o` changes only while `sclk_o` is low, so the target sees bit 7 on the first rising edge and bit 0 on the eighth.
- R7: With the card selected, the 8 bits sampled from `miso_i` on the rising edges (first bit = MSB) are readable at 0x20 after the exchange. They stay readable until the next write.
- R8: With the card deselected, the sampled input is taken as 0, so 0x20 reads 0x00 after the exchange.
- R9: `cfg_clk_o` equals `sclk_o` while page bit 6 is set and stays low otherwise.
- R10: A write to 0x20 while `busy_o` is high is ignored. The running exchange finishes with its original byte and 8 pulses.
- R11: After reset the page register is 0x00, the card is deselected (0x12 reads 0x10), 0x20 reads 0x00, and `busy_o`, `sclk_o` and `cfg_clk_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write strobe, sampled on rising clk |
| bus_rdata | output | 8 | Read data for the addressed register |
| win_any_n | input | 1 | Low: registers answer on any page |
| miso_i | input | 1 | Serial data from the card |
| sclk_o | output | 1 | Card serial clock |
| cfg_clk_o | output | 1 | Configuration-target clock |
| card_cs_n_o | output | 1 | Card select, active low |
| mosi_o | output | 1 | Serial data out |
| busy_o | output | 1 | Exchange in progress |
| bank_o | output | 4 | Flash bank number |
| hs_nv_en_o | output | 1 | Score storage area enable |
| set_nv_en_o | output | 1 | Settings storage area enable |
| cfg_sel_o | output | 1 | Configuration-target select |
| handoff_o | output | 1 | Control hand-over flag |

## Verification
The bench counts serial clock pulses on both outputs. A counter that is off by one shows up as 7 or 9 pulses, and a glitch from gating on the wrong edge shows up as an extra runt pulse. Card and configuration models shift in `mosi_o` on their own clocks. Bit order, and data that changes on the wrong edge, therefore appear as a mismatched byte. A second exchange write landing mid-transfer is aimed at a design that restarts or reloads: it would produce extra pulses or the wrong outgoing byte. Off-page writes, the override input and a deselected card check that decode and capture gating do not leak state.

// File: rtl/bxl_pkg.sv
package bxl_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned OFF_W  = 8;

    localparam logic [OFF_W-1:0] OFF_XCHG = 8'h20;
    localparam logic [OFF_W-1:0] OFF_PAGE = 8'hE0;
    localparam logic [OFF_W-1:0] OFF_LINK = 8'h12;

    // field order here fixes the bit positions of the page register
    typedef struct packed {
        logic       handoff;
        logic       cfg_sel;
        logic       set_nv;
        logic       hs_nv;
        logic [3:0] bank;
    } page_t;
endpackage

// File: rtl/bxl_regs.sv
module bxl_regs
    import bxl_pkg::*;
#(
    parameter logic [ADDR_W-OFF_W-1:0] WIN_PAGE = 8'h06,
    parameter int unsigned CS_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic              win_any_n,
    input  logic [DATA_W-1:0] xchg_val,
    output page_t             page,
    output logic              card_off,
    output logic              xchg_wr,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        page_t page;
        logic  card_off;
    } regs_t;

    regs_t st_d, st_q;
    logic  hit;
    logic [OFF_W-1:0] off;

    always_comb begin
        hit     = !win_any_n || (addr[ADDR_W-1:OFF_W] == WIN_PAGE);
        off     = addr[OFF_W-1:0];
        st_d    = st_q;
        xchg_wr = 1'b0;
        rdata   = '0;
        if (hit && wr) begin
            unique case (off)
                OFF_PAGE: st_d.page     = page_t'(wdata);
                OFF_LINK: st_d.card_off = wdata[CS_BIT];
                OFF_XCHG: xchg_wr       = 1'b1;
                default:  ;
            endcase
        end
        if (hit) begin
            unique case (off)
                OFF_PAGE: rdata = DATA_W'(st_q.page);
                OFF_LINK: rdata[CS_BIT] = st_q.card_off;
                OFF_XCHG: rdata = xchg_val;
                default:  rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.page     <= '0;
            st_q.card_off <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign page     = st_q.page;
    assign card_off = st_q.card_off;

    // R1: a write to another page leaves the registers as they were
    assert_offpage_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && win_any_n && addr[ADDR_W-1:OFF_W] != WIN_PAGE) |=> $stable(st_q))
        else $error("off-page write changed a register");

    // R2: the page register changes only through its own offset
    assert_page_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (!win_any_n || addr[ADDR_W-1:OFF_W] == WIN_PAGE) && addr[OFF_W-1:0] == OFF_PAGE)
        |=> $stable(st_q.page))
        else $error("page register changed without a write");
endmodule

// File: rtl/bxl_shift.sv
module bxl_shift #(
    parameter int unsigned W = 8,
    localparam int unsigned CNT_W = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] load_val,
    input  logic         card_sel,
    input  logic         miso,
    output logic         busy,
    output logic [W-1:0] data,
    output logic         sclk,
    output logic         mosi
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     sh;
    } eng_t;

    eng_t st_d, st_q;
    logic en_q;
    logic mosi_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.sh   = load_val;
            end
        end else begin
            st_d.sh  = {st_q.sh[W-2:0], card_sel ? miso : 1'b0};
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(W - 1)) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // clock enable and data out move only while clk is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mosi_q <= 1'b0;
        end else begin
            en_q <= st_q.busy;
            if (st_q.busy) mosi_q <= st_q.sh[W-1];
        end
    end

    assign sclk = clk & en_q;
    assign mosi = mosi_q;
    assign busy = st_q.busy;
    assign data = st_q.sh;

    // R10: a start during a transfer neither restarts nor reloads it
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1))
        else $error("exchange restarted while busy");

    // R4: the eighth bit ends the transfer
    assert_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt == CNT_W'(W - 1)) |=> !st_q.busy)
        else $error("transfer ran past eight bits");

    // R7: the received byte holds while idle
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !start) |=> $stable(st_q.sh))
        else $error("exchange data changed while idle");

    // R5: no clock enable without a transfer behind it
    assert_idle_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !$past(st_q.busy)) |-> !en_q)
        else $error("serial clock enabled while idle");
endmodule

// File: rtl/bxl_top.sv
module bxl_top
    import bxl_pkg::*;
#(
    parameter logic [7:0] WIN_PAGE = 8'h06
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_wr,
    output logic [7:0]  bus_rdata,
    input  logic        win_any_n,
    input  logic        miso_i,
    output logic        sclk_o,
    output logic        cfg_clk_o,
    output logic        card_cs_n_o,
    output logic        mosi_o,
    output logic        busy_o,
    output logic [3:0]  bank_o,
    output logic        hs_nv_en_o,
    output logic        set_nv_en_o,
    output logic        cfg_sel_o,
    output logic        handoff_o
);
    page_t             page;
    logic              card_off;
    logic              xchg_wr;
    logic [DATA_W-1:0] xchg_val;
    logic              sclk;

    bxl_regs #(.WIN_PAGE(WIN_PAGE)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .wr       (bus_wr),
        .win_any_n(win_any_n),
        .xchg_val (xchg_val),
        .page     (page),
        .card_off (card_off),
        .xchg_wr  (xchg_wr),
        .rdata    (bus_rdata)
    );

    bxl_shift #(.W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (xchg_wr),
        .load_val(bus_wdata),
        .card_sel(!card_off),
        .miso    (miso_i),
        .busy    (busy_o),
        .data    (xchg_val),
        .sclk    (sclk),
        .mosi    (mosi_o)
    );

    assign sclk_o      = sclk;
    assign cfg_clk_o   = sclk & page.cfg_sel;
    assign card_cs_n_o = card_off;
    assign bank_o      = page.bank;
    assign hs_nv_en_o  = page.hs_nv;
    assign set_nv_en_o = page.set_nv;
    assign cfg_sel_o   = page.cfg_sel;
    assign handoff_o   = page.handoff;
endmodule

// File: tb/bxl_top_bench.sv
`timescale 1ns/1ps
module bxl_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        win_any_n = 1'b1;
    logic        miso_i;
    logic        sclk_o, cfg_clk_o, card_cs_n_o, mosi_o, busy_o;
    logic [3:0]  bank_o;
    logic        hs_nv_en_o, set_nv_en_o, cfg_sel_o, handoff_o;

    int errors = 0;
    int checks = 0;
    int rise_cnt = 0, fall_cnt = 0, cfg_cnt = 0;
    int fall_base = 0;
    logic [7:0] card_reply = '0;
    logic [7:0] card_rx = '0, cfg_rx = '0;

    always #10 clk = ~clk;

    bxl_top u_bxl_top (.*);

    // card and configuration target models
    always @(posedge sclk_o) begin rise_cnt <= rise_cnt + 1; card_rx <= {card_rx[6:0], mosi_o}; end
    always @(negedge sclk_o) fall_cnt <= fall_cnt + 1;
    always @(posedge cfg_clk_o) begin cfg_cnt <= cfg_cnt + 1; cfg_rx <= {cfg_rx[6:0], mosi_o}; end
    assign miso_i = card_reply[3'(7 - ((fall_cnt - fall_base) % 8))];

    function automatic logic [7:0] exp_capture(input logic [7:0] reply, input logic sel);
        return sel ? reply : 8'h00;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // one exchange; returns busy length and pulse counts
    task automatic xfer(input logic [7:0] data, input logic card, input logic cfg,
                        input logic [7:0] reply, input logic extra_wr,
                        output int blen, output int pulses, output int cpulses);
        int r0, c0;
        bus_write(16'h0612, card ? 8'h00 : 8'h10);
        bus_write(16'h06E0, cfg ? 8'h40 : 8'h00);
        card_reply = reply;
        fall_base  = fall_cnt;
        r0 = rise_cnt; c0 = cfg_cnt;
        bus_write(16'h0620, data);
        blen = 0;
        if (extra_wr) begin
            blen = 3;
            @(negedge clk); @(negedge clk);
            bus_addr = 16'h0620; bus_wdata = ~data; bus_wr = 1'b1;
            @(negedge clk);
            bus_wr = 1'b0;
            while (busy_o && blen < 20) begin blen++; @(negedge clk); end
        end else begin
            while (busy_o && blen < 20) begin blen++; @(negedge clk); end
        end
        repeat (3) @(negedge clk);
        pulses = rise_cnt - r0;
        cpulses = cfg_cnt - c0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int blen, pulses, cp;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 busy", busy_o, 0);
        check("R11 sclk", sclk_o, 0);
        check("R11 cfg_clk", cfg_clk_o, 0);
        check("R11 cs_n", card_cs_n_o, 1);
        bus_read(16'h06E0, rd); check("R11 page", rd, 8'h00);
        bus_read(16'h0612, rd); check("R11 link", rd, 8'h10);
        bus_read(16'h0620, rd); check("R11 xchg", rd, 8'h00);

        // R2 page fields
        bus_write(16'h06E0, 8'hB7);
        check("R2 bank", bank_o, 4'h7);
        check("R2 hs_nv", hs_nv_en_o, 1);
        check("R2 set_nv", set_nv_en_o, 1);
        check("R2 cfg_sel", cfg_sel_o, 0);
        check("R2 handoff", handoff_o, 1);
        bus_read(16'h06E0, rd); check("R2 readback", rd, 8'hB7);

        // R1 decode: off page ignored, override answers anywhere
        bus_write(16'h07E0, 8'h5A);
        bus_read(16'h06E0, rd); check("R1 offpage write ignored", rd, 8'hB7);
        bus_read(16'h07E0, rd); check("R1 offpage read zero", rd, 8'h00);
        win_any_n = 1'b0;
        bus_write(16'h3CE0, 8'h4A);
        bus_read(16'hFF12, rd); check("R1 override read link", rd, 8'h10);
        win_any_n = 1'b1;
        bus_read(16'h06E0, rd); check("R1 override write", rd, 8'h4A);
        check("R2 cfg_sel set", cfg_sel_o, 1);

        // R3 link register
        bus_write(16'h0612, 8'hEF);
        check("R3 cs_n low", card_cs_n_o, 0);
        bus_read(16'h0612, rd); check("R3 readback", rd, 8'h00);

        // directed exchange: card and config both selected
        xfer(8'hA5, 1'b1, 1'b1, 8'h3C, 1'b0, blen, pulses, cp);
        check("R4 busy length", blen, 8);
        check("R5 sclk pulses", pulses, 8);
        check("R5 sclk idle", sclk_o, 0);
        check("R6 card got MSB first", card_rx, 8'hA5);
        check("R9 cfg pulses", cp, 8);
        check("R9 cfg byte", cfg_rx, 8'hA5);
        bus_read(16'h0620, rd); check("R7 capture", rd, 8'h3C);
        repeat (5) @(negedge clk);
        bus_read(16'h0620, rd); check("R7 held", rd, 8'h3C);

        // R8 card deselected
        xfer(8'h81, 1'b0, 1'b0, 8'hFF, 1'b0, blen, pulses, cp);
        bus_read(16'h0620, rd); check("R8 deselected reads zero", rd, 8'h00);
        check("R9 cfg off no pulses", cp, 0);
        check("R5 pulses deselected", pulses, 8);

        // R10 write during busy
        xfer(8'h6E, 1'b1, 1'b0, 8'h91, 1'b1, blen, pulses, cp);
        check("R10 busy length", blen, 8);
        check("R10 pulses", pulses, 8);
        check("R10 original byte out", card_rx, 8'h6E);
        bus_read(16'h0620, rd); check("R10 capture intact", rd, 8'h91);

        // random exchanges
        for (int i = 0; i < 30; i++) begin
            logic [7:0] d, rp;
            logic cs, cf;
            d  = 8'($urandom);
            rp = 8'($urandom);
            cs = 1'($urandom);
            cf = 1'($urandom);
            xfer(d, cs, cf, rp, 1'b0, blen, pulses, cp);
            check("R4 random busy", blen, 8);
            check("R6 random out", card_rx, d);
            check("R9 random cfg pulses", cp, cf ? 8 : 0);
            bus_read(16'h0620, rd);
            check(cs ? "R7 random capture" : "R8 random capture", rd, exp_capture(rp, cs));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule